// File: doc/BRIEF.md
# Doorbell Mailbox Command Sequencer

This block runs a single mailbox command for a local requester. The requester hands over an opcode, an input length in bytes and an output buffer limit, and says whether an output buffer exists. The block then works the mailbox through a register bus. First it waits for the doorbell to go idle and checks the device health word. Next it writes the command word and the input payload words and rings the doorbell. It then polls until the doorbell clears and reads back the return code. If the return code is zero, it also reads the output length and the output payload words.

The wait has a time limit. The limit is a cycle budget, by default two seconds at the clock rate. When the budget runs out, the doorbell is read once more before the block reports a timeout. The requester receives a one-cycle completion pulse with a two-bit result, the device return code and an output length. The output length is clamped to the smallest of three values: the buffer limit, the mailbox payload capacity and the length the device reports. Payload transfer is counted as bus accesses; data is not buffered.

Top module: `mbox_cmd_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle, one request is accepted per `req_valid`&`req_ready` cycle, and `rsp_done` is a single-cycle pulse per accepted request. Result codes on `rsp_status`: 0 ok, 1 busy, 2 fault, 3 timeout.
- R2: After acceptance the block reads the control register at 0x000 (bit 0 = doorbell) until bit 0 reads 0. If it is still 1 after TMO_CYCLES wait cycles, the block does one more read and reports timeout only if that read is also busy. No write is issued in that case.
- R3: Once the doorbell is idle, the block reads the health word at 0x018. Unless bit 4 (interface ready) is 1 and bits [3:2] equal 2'b01 (media ready), it reports busy without any write.
- R4: With both ready conditions met, a set bit 0 (fatal), bit 1 (firmware halted) or any set bit in [7:5] (reset required) makes the block report fault without any write.
- R5: The block then reads the control register again. If the doorbell is busy, it reports busy without any write.
- R6: The write order is: the command word at 0x008 (opcode in [15:0], input length in [36:16]); then ceil(in_len/8) payload words at 0x100 + 8·i; then a write of 1 to the control register, which is always the last write.
- R7: The completion wait after the doorbell write follows the same rule as R2. A doorbell that clears on the extra read gives a normal completion; a doorbell busy on that read too gives timeout.
- R8: The block reads the return code from [47:32] of 0x010. A nonzero code ends the command with result ok, that code, output length 0, and no read of 0x008.
- R9: With a zero code, the block reads the device length from [36:16] of 0x008. It reports min(req_out_max, PAY_BYTES, device length) and reads ceil(that/8) payload words.
- R10: When `req_out_en` is 0, the reported output length is 0 and no output payload word is read.
- R11: The wait-cycle budget restarts on every request and on every doorbell write, so back-to-back commands each get the full budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_opcode | input | 16 | Command opcode |
| req_in_len | input | LW | Input payload length in bytes |
| req_out_max | input | LW | Output buffer limit in bytes |
| req_out_en | input | 1 | An output buffer is supplied |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | Result code |
| rsp_code | output | 16 | Device return code |
| rsp_out_len | output | LW | Clamped output length |
| bus_valid | output | 1 | Register access request |
| bus_write | output | 1 | Access is a write |
| bus_addr | output | AW | Register byte address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | 64 | Read data, valid with bus_ack |

## Verification
The assertions assume that `bus_ack` comes only while `bus_valid` is high and that `req_valid` is held until it is accepted. The bench's register model acknowledges every access in the cycle it is presented and raises requests only while `req_ready` is high.

The model makes the doorbell read busy for a programmed number of reads rather than a programmed number of cycles. Under single-cycle acknowledge this lands the extra read exactly on the boundary between clearing and timing out.

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TMO_CYCLES = 2 * CLK_HZ,
  parameter int PAY_BYTES  = 256,
  parameter int AW         = 12,
  parameter int LW         = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [15:0]   req_opcode,
  input  logic [LW-1:0] req_in_len,
  input  logic [LW-1:0] req_out_max,
  input  logic          req_out_en,
  output logic          rsp_done,
  output logic [1:0]    rsp_status,
  output logic [15:0]   rsp_code,
  output logic [LW-1:0] rsp_out_len,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [63:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [63:0]   bus_rdata
);

  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYCLES - 1);
  localparam logic [LW-1:0] PAY_LIM  = LW'(PAY_BYTES);
  localparam logic [AW-1:0] A_CTRL = AW'(12'h000);
  localparam logic [AW-1:0] A_CMD  = AW'(12'h008);
  localparam logic [AW-1:0] A_STAT = AW'(12'h010);
  localparam logic [AW-1:0] A_HLTH = AW'(12'h018);
  localparam logic [AW-1:0] A_PAY  = AW'(12'h100);
  localparam logic [1:0] ST_OK = 2'd0, ST_BUSY = 2'd1, ST_FAULT = 2'd2, ST_TMO = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_W1, S_W1F, S_HLTH, S_CHK, S_WCMD, S_WPAY, S_RING,
    S_W2, S_W2F, S_STAT, S_RLEN, S_RPAY
  } state_t;

  state_t        state;
  logic [TW-1:0] cnt;
  logic [LW-1:0] wcnt, wtot;
  logic [15:0]   op_q;
  logic [LW-1:0] inlen_q, omax_q;
  logic          oen_q;

  function automatic logic [LW-1:0] min2(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [LW-1:0] nwords(input logic [LW-1:0] n);
    logic [LW:0] t;
    t = {1'b0, n} + (LW+1)'(7);
    return LW'(t[LW:3]);
  endfunction

  wire            db_busy  = bus_rdata[0];
  wire            rdy_ok   = bus_rdata[4] && (bus_rdata[3:2] == 2'b01);
  wire            hlth_bad = bus_rdata[0] | bus_rdata[1] | (|bus_rdata[7:5]);
  wire [15:0]     rc       = bus_rdata[47:32];
  wire [LW-1:0]   dev_len  = bus_rdata[16 +: LW];
  wire [LW-1:0]   n_clamp  = min2(omax_q, min2(PAY_LIM, dev_len));
  wire [AW-1:0]   pay_addr = A_PAY + AW'({wcnt, 3'b000});
  wire            polling  = (state == S_W1) || (state == S_W2);

  assign req_ready = (state == S_IDLE);

  always_comb begin
    bus_valid = 1'b1;
    bus_write = 1'b0;
    bus_addr  = A_CTRL;
    bus_wdata = '0;
    case (state)
      S_IDLE: bus_valid = 1'b0;
      S_HLTH: bus_addr = A_HLTH;
      S_WCMD: begin
        bus_write = 1'b1;
        bus_addr  = A_CMD;
        bus_wdata = 64'(op_q) | (64'(inlen_q) << 16);
      end
      S_WPAY: begin
        bus_write = 1'b1;
        bus_addr  = pay_addr;
      end
      S_RING: begin
        bus_write = 1'b1;
        bus_wdata = 64'd1;
      end
      S_STAT: bus_addr = A_STAT;
      S_RLEN: bus_addr = A_CMD;
      S_RPAY: bus_addr = pay_addr;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      wcnt        <= '0;
      wtot        <= '0;
      op_q        <= '0;
      inlen_q     <= '0;
      omax_q      <= '0;
      oen_q       <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_status  <= ST_OK;
      rsp_code    <= '0;
      rsp_out_len <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (polling && cnt != TMO_LAST) cnt <= cnt + 1'b1;
      case (state)
        S_IDLE: if (req_valid) begin
          op_q    <= req_opcode;
          inlen_q <= req_in_len;
          omax_q  <= req_out_max;
          oen_q   <= req_out_en;
          cnt     <= '0;
          state   <= S_W1;
        end
        S_W1, S_W2: if (bus_ack) begin
          if (!db_busy)             state <= (state == S_W1) ? S_HLTH : S_STAT;
          else if (cnt == TMO_LAST) state <= (state == S_W1) ? S_W1F : S_W2F;
        end
        S_W1F, S_W2F: if (bus_ack) begin
          if (db_busy) begin
            rsp_done <= 1'b1; rsp_status <= ST_TMO; rsp_code <= '0; rsp_out_len <= '0;
            state <= S_IDLE;
          end else begin
            state <= (state == S_W1F) ? S_HLTH : S_STAT;
          end
        end
        S_HLTH: if (bus_ack) begin
          if (!rdy_ok || hlth_bad) begin
            rsp_done <= 1'b1; rsp_status <= rdy_ok ? ST_FAULT : ST_BUSY;
            rsp_code <= '0; rsp_out_len <= '0;
            state <= S_IDLE;
          end else begin
            state <= S_CHK;
          end
        end
        S_CHK: if (bus_ack) begin
          if (db_busy) begin
            rsp_done <= 1'b1; rsp_status <= ST_BUSY; rsp_code <= '0; rsp_out_len <= '0;
            state <= S_IDLE;
          end else begin
            state <= S_WCMD;
          end
        end
        S_WCMD: if (bus_ack) begin
          wcnt  <= '0;
          wtot  <= nwords(inlen_q);
          state <= (inlen_q != '0) ? S_WPAY : S_RING;
        end
        S_WPAY: if (bus_ack) begin
          if (wcnt == wtot - 1'b1) state <= S_RING;
          else wcnt <= wcnt + 1'b1;
        end
        S_RING: if (bus_ack) begin
          cnt   <= '0;
          state <= S_W2;
        end
        S_STAT: if (bus_ack) begin
          rsp_code <= rc;
          if (rc != '0) begin
            rsp_done <= 1'b1; rsp_status <= ST_OK; rsp_out_len <= '0;
            state <= S_IDLE;
          end else begin
            state <= S_RLEN;
          end
        end
        S_RLEN: if (bus_ack) begin
          if (oen_q && n_clamp != '0) begin
            rsp_out_len <= n_clamp;
            wcnt  <= '0;
            wtot  <= nwords(n_clamp);
            state <= S_RPAY;
          end else begin
            rsp_done <= 1'b1; rsp_status <= ST_OK; rsp_out_len <= '0;
            state <= S_IDLE;
          end
        end
        S_RPAY: if (bus_ack) begin
          if (wcnt == wtot - 1'b1) begin
            rsp_done <= 1'b1; rsp_status <= ST_OK;
            state <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic wr_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= 1'b0;
    else if (req_valid && req_ready) wr_seen <= 1'b0;
    else if (bus_valid && bus_write && bus_ack) wr_seen <= 1'b1;
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R3 R4 R5
  no_write_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && (rsp_status == ST_BUSY || rsp_status == ST_FAULT)) |-> !wr_seen);
  // R9
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_out_len <= PAY_LIM));
  // R8
  len_zero_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && (rsp_status != ST_OK || rsp_code != '0)) |-> (rsp_out_len == '0));
  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));

endmodule

// File: tb/test_mbox_cmd_seq.sv
module test_mbox_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;
  localparam int AW = 12;
  localparam int LW = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_out_en = 1'b0;
  logic [15:0] req_opcode = '0;
  logic [LW-1:0] req_in_len = '0, req_out_max = '0;
  logic rsp_done;
  logic [1:0] rsp_status;
  logic [15:0] rsp_code;
  logic [LW-1:0] rsp_out_len;
  logic bus_valid, bus_write, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [63:0] bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_cmd_seq #(.CLK_HZ(20), .TMO_CYCLES(TMO), .PAY_BYTES(256), .AW(AW), .LW(LW)) i_mbox_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_in_len(req_in_len), .req_out_max(req_out_max),
    .req_out_en(req_out_en), .rsp_done(rsp_done), .rsp_status(rsp_status),
    .rsp_code(rsp_code), .rsp_out_len(rsp_out_len), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int busy_left, k_ring, wr_cnt, pay_wr, pay_rd, cmd_rd, last_wr_addr;
  bit rebusy;
  logic [63:0] hlth, cmd_wdata;
  logic [15:0] rc_reg;
  logic [LW-1:0] len_reg;

  assign bus_ack = bus_valid;
  always_comb begin
    bus_rdata = '0;
    if (!bus_write)
      case (bus_addr)
        12'h000: bus_rdata = {63'b0, busy_left != 0};
        12'h008: bus_rdata = 64'(len_reg) << 16;
        12'h010: bus_rdata = 64'(rc_reg) << 32;
        12'h018: bus_rdata = hlth;
        default: bus_rdata = '0;
      endcase
  end

  always @(posedge clk) if (bus_valid && bus_ack) begin
    if (bus_write) begin
      wr_cnt = wr_cnt + 1;
      last_wr_addr = int'(bus_addr);
      if (bus_addr == 12'h008) cmd_wdata = bus_wdata;
      if (bus_addr >= 12'h100) pay_wr = pay_wr + 1;
      if (bus_addr == 12'h000 && bus_wdata[0]) busy_left = k_ring;
    end else begin
      if (bus_addr == 12'h000 && busy_left != 0) busy_left = busy_left - 1;
      if (bus_addr == 12'h018 && rebusy) busy_left = 1;
      if (bus_addr == 12'h008) cmd_rd = cmd_rd + 1;
      if (bus_addr >= 12'h100) pay_rd = pay_rd + 1;
    end
  end

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input int pre, input int kr, input logic [63:0] h,
                       input logic [15:0] rc, input int dlen, input bit rb);
    busy_left = pre; k_ring = kr; hlth = h; rc_reg = rc; len_reg = LW'(dlen); rebusy = rb;
    wr_cnt = 0; pay_wr = 0; pay_rd = 0; cmd_rd = 0; last_wr_addr = -1; cmd_wdata = '0;
  endtask

  task automatic run(input logic [15:0] op, input int inl, input int omax, input bit oen);
    @(negedge clk);
    req_opcode = op; req_in_len = LW'(inl); req_out_max = LW'(omax); req_out_en = oen;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (rsp_done) break;
      @(negedge clk);
    end
    if (!rsp_done) begin
      n_chk++; n_bad++;
      $display("FAIL R1: no completion, actual 0 expected 1");
    end
  endtask

  localparam logic [63:0] GOOD = 64'h14;

  task automatic t_out_clamp_req;
    model(2, 3, GOOD, 16'h0, 100, 0);
    run(16'h0401, 0, 64, 1);
    chk("R9 status", rsp_status, 0);
    chk("R9 len=min(req)", rsp_out_len, 64);
    chk("R9 payload reads", pay_rd, 8);
    chk("R6 ring-only writes", wr_cnt, 2);
  endtask

  task automatic t_out_clamp_pay;
    model(0, 1, GOOD, 16'h0, 400, 0);
    run(16'h0402, 0, 1000, 1);
    chk("R9 len=min(payload)", rsp_out_len, 256);
    chk("R9 payload reads", pay_rd, 32);
  endtask

  task automatic t_out_clamp_dev;
    model(0, 0, GOOD, 16'h0, 21, 0);
    run(16'h0403, 0, 200, 1);
    chk("R9 len=min(device)", rsp_out_len, 21);
    chk("R9 payload reads", pay_rd, 3);
  endtask

  task automatic t_no_buffer;
    model(0, 2, GOOD, 16'h0, 50, 0);
    run(16'h0404, 0, 200, 0);
    chk("R10 status", rsp_status, 0);
    chk("R10 len", rsp_out_len, 0);
    chk("R10 payload reads", pay_rd, 0);
  endtask

  task automatic t_input_payload;
    model(0, 2, GOOD, 16'h0, 0, 0);
    run(16'h1234, 20, 0, 0);
    chk("R6 command word", cmd_wdata, (64'd20 << 16) | 64'h1234);
    chk("R6 payload writes", pay_wr, 3);
    chk("R6 total writes", wr_cnt, 5);
    chk("R6 doorbell last", last_wr_addr, 0);
  endtask

  task automatic t_nonzero_rc;
    model(0, 1, GOOD, 16'h00A5, 40, 0);
    run(16'h0405, 0, 200, 1);
    chk("R8 status", rsp_status, 0);
    chk("R8 code", rsp_code, 16'h00A5);
    chk("R8 len", rsp_out_len, 0);
    chk("R8 no length read", cmd_rd, 0);
  endtask

  task automatic t_not_ready;
    model(0, 0, 64'h10, 16'h0, 0, 0);
    run(16'h0406, 8, 0, 0);
    chk("R3 media missing", rsp_status, 1);
    chk("R3 no writes", wr_cnt, 0);
    model(0, 0, 64'h04, 16'h0, 0, 0);
    run(16'h0406, 8, 0, 0);
    chk("R3 interface missing", rsp_status, 1);
    chk("R3 no writes", wr_cnt, 0);
  endtask

  task automatic t_fault;
    logic [63:0] bad [3] = '{64'h15, 64'h16, 64'h34};
    for (int i = 0; i < 3; i++) begin
      model(0, 0, bad[i], 16'h0, 0, 0);
      run(16'h0407, 8, 0, 0);
      chk("R4 fault", rsp_status, 2);
      chk("R4 no writes", wr_cnt, 0);
    end
  endtask

  task automatic t_rebusy;
    model(0, 0, GOOD, 16'h0, 0, 1);
    run(16'h0408, 8, 0, 0);
    chk("R5 busy", rsp_status, 1);
    chk("R5 no writes", wr_cnt, 0);
  endtask

  task automatic t_pre_timeout;
    model(TMO + 1, 0, GOOD, 16'h0, 0, 0);
    run(16'h0409, 8, 0, 0);
    chk("R2 timeout", rsp_status, 3);
    chk("R2 no writes", wr_cnt, 0);
    model(TMO, 0, GOOD, 16'h0, 0, 0);
    run(16'h0409, 0, 0, 0);
    chk("R2 clears on extra read", rsp_status, 0);
  endtask

  task automatic t_post_timeout;
    model(0, TMO, GOOD, 16'h0, 16, 0);
    run(16'h040A, 0, 64, 1);
    chk("R7 clears on extra read", rsp_status, 0);
    chk("R7 len", rsp_out_len, 16);
    model(0, TMO, GOOD, 16'h0, 16, 0);
    run(16'h040A, 0, 64, 1);
    chk("R11 budget restarts", rsp_status, 0);
    model(0, TMO + 1, GOOD, 16'h0, 16, 0);
    run(16'h040A, 0, 64, 1);
    chk("R7 timeout", rsp_status, 3);
    chk("R7 len", rsp_out_len, 0);
    chk("R7 no readback", cmd_rd, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R1: watchdog expired, actual %0d expected below 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model(0, 0, GOOD, 16'h0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset done", rsp_done, 0);
    chk("R1 reset bus idle", bus_valid, 0);
    t_out_clamp_req();
    t_out_clamp_pay();
    t_out_clamp_dev();
    t_no_buffer();
    t_input_payload();
    t_nonzero_rc();
    t_not_ready();
    t_fault();
    t_rebusy();
    t_pre_timeout();
    t_post_timeout();
    @(negedge clk);
    chk("R1 single pulse", rsp_done, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule